// File: doc/BRIEF.md
# Vector-Scalar Pipe Issue Arbiter

This block sits at the issue stage in front of two vector-scalar execution pipes, VS1 and VS2. Each cycle it is offered up to two candidate operations in age order: slot 0 is older and slot 1 is younger. Each candidate has a valid bit, a 3-bit kind code and a flag that marks an operation reading four single-precision inputs. In the same cycle the block decides which pipe, if any, takes each candidate. It raises a per-slot stall for every valid candidate it cannot place. The upstream queue holds a stalled candidate and offers it again.

Pipe affinity comes from the kind. Some kinds are fixed to one pipe, and the floating-point kinds can run on either. Two hazards limit the choice:
- A four-input single-precision operation on VS1 keeps any floating-point operation off VS2 in that same cycle.
- VS1's simple-vector (XS) path shares a result write-back port with its vector floating-point path. The two latencies differ by `WB_GAP` cycles, so an XS operation cannot enter VS1 exactly `WB_GAP` cycles after a vector floating-point operation entered VS1.

Within these rules the arbiter places as many candidates as it can. Issue stays in order: the younger slot never goes while the older one stalls.

Top module: `vs_issue_arb`

## Requirements
- R1: Kind codes 0 (vector integer) and 1 (XS simple vector) are only ever granted VS1.
- R2: Kind codes 2 (permute/select) and 3 (128-bit store data) are only ever granted VS2.
- R3: Kind codes 4 (scalar FP), 5 (vector FP), and the unused codes 6 and 7 (treated as scalar FP) may take either pipe. A floating-point candidate takes VS1 unless one of these holds, in which case it takes VS2:
  - VS1 is already granted to the older slot.
  - Giving VS1 to the younger candidate instead lets both slots be placed. A lone floating-point candidate, with the other slot empty, takes VS1.
- R4: When VS1 is granted to a candidate whose four-input flag is set, VS2 is not granted to a floating-point kind (4 to 7) in the same cycle.
- R5: A kind 1 candidate is not granted VS1 in a cycle exactly `WB_GAP` (default 5) cycles after a cycle in which VS1 was granted a kind 5 candidate. At 4 or 6 cycles apart it is granted.
- R6: Each pipe is granted to at most one slot per cycle, and only to a valid slot. Grants to the two pipes go to different slots. The slot outputs name the granted slot (0 older, 1 younger).
- R7: `stall[i]` is high exactly when slot i is valid and not granted. Slot 1 is never granted while slot 0 is valid and stalled. A held candidate is granted once its hazard has passed.
- R8: Reset clears the write-back history, so an XS candidate after reset is not blocked by a vector FP grant made before reset. With no valid candidate, all grants and stalls are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Candidate valid per slot (bit 0 older) |
| req_kind | input | 2x3 | Kind code per slot |
| req_quad | input | 2 | Four single-precision inputs flag per slot |
| gnt_vs1 | output | 1 | VS1 granted this cycle |
| gnt_vs1_slot | output | 1 | Slot granted VS1 |
| gnt_vs2 | output | 1 | VS2 granted this cycle |
| gnt_vs2_slot | output | 1 | Slot granted VS2 |
| stall | output | 2 | Valid candidate not placed, per slot |

## Verification
Grants and stalls are combinational from the candidates and the history register, so they are due in the cycle the candidates are presented. The bench samples them two nanoseconds after driving at the falling edge, before the next rising edge. The write-back hazard is due exactly `WB_GAP` cycles after a vector FP grant to VS1. The bench keeps its own record of such grants and advances it once per rising edge. The gap tests are built cycle by cycle, at distances 4, 5 and 6 and across a reset. Placement is checked against a bench model that enumerates every pipe assignment, discards the illegal ones and keeps the best.

// File: rtl/vs_arb_pkg.sv
package vs_arb_pkg;

    localparam int NUM_SLOTS = 2;
    localparam int KIND_W    = 3;

    typedef enum logic [KIND_W-1:0] {
        K_VINT  = 3'd0,
        K_VXS   = 3'd1,
        K_PERM  = 3'd2,
        K_STDAT = 3'd3,
        K_SFP   = 3'd4,
        K_VFP   = 3'd5,
        K_RSV6  = 3'd6,
        K_RSV7  = 3'd7
    } vs_kind_e;

    typedef enum logic [1:0] {
        P_NONE = 2'd0,
        P_VS1  = 2'd1,
        P_VS2  = 2'd2
    } vs_pipe_e;

    typedef struct packed {
        logic valid;
        logic vs1_only;
        logic vs2_only;
        logic fp;
        logic vfp;
        logic quad;
        logic blocked;   // XS candidate hit by write-back hazard
    } slot_info_t;

    function automatic logic kind_vs1_only(input logic [KIND_W-1:0] k);
        return (k == K_VINT) || (k == K_VXS);
    endfunction

    function automatic logic kind_vs2_only(input logic [KIND_W-1:0] k);
        return (k == K_PERM) || (k == K_STDAT);
    endfunction

    function automatic logic kind_fp(input logic [KIND_W-1:0] k);
        return k[2];
    endfunction

endpackage

// File: rtl/vs_wb_history.sv
module vs_wb_history
    import vs_arb_pkg::*;
#(
    parameter int WB_GAP = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic vfp_on_vs1,
    output logic xs_hazard
);
    localparam int HW = WB_GAP;

    // bit 0: one cycle ago ... bit HW-1: WB_GAP cycles ago
    logic [HW-1:0] hist_q;

    generate
        if (HW == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= vfp_on_vs1;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= {hist_q[HW-2:0], vfp_on_vs1};
            end
        end
    endgenerate

    assign xs_hazard = hist_q[HW-1];

    // R8: history is empty in the cycle right after reset
    a_r8_hist_cleared: assert property (@(posedge clk)
        rst |=> (hist_q == '0));

endmodule

// File: rtl/vs_req_decode.sv
module vs_req_decode
    import vs_arb_pkg::*;
(
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    input  logic              quad,
    input  logic              xs_hazard,
    output slot_info_t        info
);
    always_comb begin
        info          = '0;
        info.valid    = valid;
        info.vs1_only = kind_vs1_only(kind);
        info.vs2_only = kind_vs2_only(kind);
        info.fp       = kind_fp(kind);
        info.vfp      = (kind == K_VFP);
        info.quad     = quad;
        info.blocked  = (kind == K_VXS) && xs_hazard;
    end
endmodule

// File: rtl/vs_pipe_place.sv
module vs_pipe_place
    import vs_arb_pkg::*;
(
    input  slot_info_t sa,   // older slot
    input  slot_info_t sb,   // younger slot
    output vs_pipe_e   a_pipe,
    output vs_pipe_e   b_pipe
);
    logic yield_vs1;
    logic b_may_go;
    logic free1, free2, quad_block2, a_fp_on_vs2;

    always_comb begin
        // an FP older slot gives up VS1 when that lets the younger one go too
        yield_vs1 = sb.valid && !sb.quad &&
                    ((sb.vs1_only && !sb.blocked) || (sa.quad && sb.fp));

        a_pipe = P_NONE;
        if (sa.valid) begin
            if (sa.vs1_only)      a_pipe = sa.blocked ? P_NONE : P_VS1;
            else if (sa.vs2_only) a_pipe = P_VS2;
            else                  a_pipe = yield_vs1 ? P_VS2 : P_VS1;
        end

        b_may_go    = !sa.valid || (a_pipe != P_NONE);
        free1       = (a_pipe != P_VS1);
        free2       = (a_pipe != P_VS2);
        quad_block2 = (a_pipe == P_VS1) && sa.quad;
        a_fp_on_vs2 = (a_pipe == P_VS2) && sa.fp;

        b_pipe = P_NONE;
        if (sb.valid && b_may_go) begin
            if (sb.vs1_only) begin
                if (free1 && !sb.blocked) b_pipe = P_VS1;
            end else if (sb.vs2_only) begin
                if (free2) b_pipe = P_VS2;
            end else begin
                if (free1 && !(sb.quad && a_fp_on_vs2)) b_pipe = P_VS1;
                else if (free2 && !quad_block2)         b_pipe = P_VS2;
            end
        end
    end
endmodule

// File: rtl/vs_issue_arb.sv
module vs_issue_arb
    import vs_arb_pkg::*;
#(
    parameter int WB_GAP = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_SLOTS-1:0]              req_valid,
    input  logic [NUM_SLOTS-1:0][KIND_W-1:0]  req_kind,
    input  logic [NUM_SLOTS-1:0]              req_quad,
    output logic                              gnt_vs1,
    output logic                              gnt_vs1_slot,
    output logic                              gnt_vs2,
    output logic                              gnt_vs2_slot,
    output logic [NUM_SLOTS-1:0]              stall
);
    localparam int CW = $clog2(WB_GAP + 2);
    localparam logic [CW-1:0] CNT_SAT = CW'(WB_GAP + 1);

    logic       xs_hazard;
    logic       vfp_on_vs1;
    slot_info_t info [NUM_SLOTS];
    vs_pipe_e   a_pipe, b_pipe;

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
            vs_req_decode u_dec (
                .valid     (req_valid[i]),
                .kind      (req_kind[i]),
                .quad      (req_quad[i]),
                .xs_hazard (xs_hazard),
                .info      (info[i])
            );
        end
    endgenerate

    vs_pipe_place u_place (
        .sa     (info[0]),
        .sb     (info[1]),
        .a_pipe (a_pipe),
        .b_pipe (b_pipe)
    );

    assign vfp_on_vs1 = ((a_pipe == P_VS1) && info[0].vfp) ||
                        ((b_pipe == P_VS1) && info[1].vfp);

    vs_wb_history #(.WB_GAP(WB_GAP)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .vfp_on_vs1 (vfp_on_vs1),
        .xs_hazard  (xs_hazard)
    );

    assign gnt_vs1      = (a_pipe == P_VS1) || (b_pipe == P_VS1);
    assign gnt_vs1_slot = (b_pipe == P_VS1);
    assign gnt_vs2      = (a_pipe == P_VS2) || (b_pipe == P_VS2);
    assign gnt_vs2_slot = (b_pipe == P_VS2);
    assign stall[0]     = req_valid[0] && (a_pipe == P_NONE);
    assign stall[1]     = req_valid[1] && (b_pipe == P_NONE);

    // independent distance counter: cycles since VS1 last took a vector FP op
    logic [CW-1:0] since_vfp_q;
    always_ff @(posedge clk) begin
        if (rst)
            since_vfp_q <= CNT_SAT;
        else if (gnt_vs1 && (req_kind[gnt_vs1_slot] == K_VFP))
            since_vfp_q <= CW'(1);
        else if (since_vfp_q != CNT_SAT)
            since_vfp_q <= since_vfp_q + CW'(1);
    end

    a_r1_fixed_kinds_off_vs2: assert property (@(posedge clk) disable iff (rst)
        gnt_vs2 |-> !kind_vs1_only(req_kind[gnt_vs2_slot]));

    a_r2_fixed_kinds_off_vs1: assert property (@(posedge clk) disable iff (rst)
        gnt_vs1 |-> !kind_vs2_only(req_kind[gnt_vs1_slot]));

    a_r4_quad_blocks_fp_vs2: assert property (@(posedge clk) disable iff (rst)
        (gnt_vs1 && req_quad[gnt_vs1_slot] && gnt_vs2)
            |-> !kind_fp(req_kind[gnt_vs2_slot]));

    a_r5_wb_gap_respected: assert property (@(posedge clk) disable iff (rst)
        (gnt_vs1 && (req_kind[gnt_vs1_slot] == K_VXS))
            |-> (since_vfp_q != CW'(WB_GAP)));

    a_r6_distinct_valid_slots: assert property (@(posedge clk) disable iff (rst)
        (gnt_vs1 |-> req_valid[gnt_vs1_slot]) and
        (gnt_vs2 |-> req_valid[gnt_vs2_slot]) and
        ((gnt_vs1 && gnt_vs2) |-> (gnt_vs1_slot != gnt_vs2_slot)));

    a_r7_in_order: assert property (@(posedge clk) disable iff (rst)
        ((gnt_vs1 && gnt_vs1_slot) || (gnt_vs2 && gnt_vs2_slot)) |-> !stall[0]);

endmodule

// File: tb/vs_issue_arb_test.sv
module vs_issue_arb_test;
    localparam int GAP = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst;
    logic [1:0]      req_valid;
    logic [1:0][2:0] req_kind;
    logic [1:0]      req_quad;
    logic            gnt_vs1, gnt_vs1_slot, gnt_vs2, gnt_vs2_slot;
    logic [1:0]      stall;

    vs_issue_arb #(.WB_GAP(GAP)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_quad(req_quad), .gnt_vs1(gnt_vs1), .gnt_vs1_slot(gnt_vs1_slot),
        .gnt_vs2(gnt_vs2), .gnt_vs2_slot(gnt_vs2_slot), .stall(stall)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [GAP:1] mh;   // mh[k]: VS1 took a vector FP op k cycles ago
    logic [5:0] m_out;
    logic       m_vfp;

    function automatic bit place_ok(int p, logic v, int k);
        if (!v) return p == 0;
        if (k <= 1 && p == 2) return 0;
        if ((k == 2 || k == 3) && p == 1) return 0;
        if (k == 1 && mh[GAP] && p == 1) return 0;
        return 1;
    endfunction

    task automatic run_model();
        int best;
        int ka, kb;
        best = -1;
        ka = int'(req_kind[0]);
        kb = int'(req_kind[1]);
        m_out = '0;
        m_vfp = 1'b0;
        for (int pa = 0; pa < 3; pa++) begin
            for (int pb = 0; pb < 3; pb++) begin
                int sc;
                if (!place_ok(pa, req_valid[0], ka)) continue;
                if (!place_ok(pb, req_valid[1], kb)) continue;
                if (pa != 0 && pa == pb) continue;
                if (pa == 1 && req_quad[0] && pb == 2 && kb >= 4) continue;
                if (pb == 1 && req_quad[1] && pa == 2 && ka >= 4) continue;
                if (pb != 0 && req_valid[0] && pa == 0) continue;
                sc = 8 * (int'(pa != 0) + int'(pb != 0)) + 2 * int'(pa == 1) + int'(pb == 1);
                if (sc > best) begin
                    best = sc;
                    m_out = {(pa == 1 || pb == 1), (pb == 1), (pa == 2 || pb == 2), (pb == 2),
                             (req_valid[1] && pb == 0), (req_valid[0] && pa == 0)};
                    m_vfp = (pa == 1 && ka == 5) || (pb == 1 && kb == 5);
                end
            end
        end
    endtask

    function automatic logic [5:0] actual();
        return {gnt_vs1, gnt_vs1_slot, gnt_vs2, gnt_vs2_slot, stall[1], stall[0]};
    endfunction

    task automatic compare(string tag, logic [5:0] exp);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (vld=%b k0=%0d k1=%0d q=%b)",
                     tag, actual(), exp, req_valid, req_kind[0], req_kind[1], req_quad);
        end
    endtask

    // drive at falling edge, sample 2 ns later, then account for the next rising edge
    task automatic step(logic va, int ka, logic qa, logic vb, int kb, logic qb,
                        string tag, bit use_exp, logic [5:0] exp);
        @(negedge clk);
        req_valid = {vb, va};
        req_kind  = {3'(kb), 3'(ka)};
        req_quad  = {qb, qa};
        #2;
        run_model();
        compare(tag, m_out);
        if (use_exp) compare(tag, exp);
        mh = {mh[GAP-1:1], m_vfp};
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, tag, 1, 6'b000000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        mh = '0;
        @(negedge clk);
        #2;
        compare("R8 outputs idle in reset", 6'b000000);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = '0;
        req_kind = '0;
        req_quad = '0;
        mh = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        idle("R8 reset state");
        // R1 fixed VS1 kinds
        step(1, 0, 0, 0, 0, 0, "R1 vint alone", 1, 6'b100000);
        step(0, 0, 0, 1, 1, 0, "R1 xs in younger slot", 1, 6'b110000);
        // R2 fixed VS2 kinds
        step(1, 2, 0, 0, 0, 0, "R2 perm alone", 1, 6'b001000);
        step(1, 3, 0, 1, 2, 0, "R2 store data vs perm", 1, 6'b001010);
        // R3 flexible FP placement
        step(1, 4, 0, 0, 0, 0, "R3 fp alone prefers VS1", 1, 6'b100000);
        step(1, 4, 0, 1, 0, 0, "R3 fp yields VS1 to vint", 1, 6'b111000);
        step(1, 5, 0, 1, 4, 0, "R3 two fp split", 1, 6'b101100);
        // R4 four-input cross-pipe rule
        step(1, 4, 1, 1, 4, 0, "R4 quad fp moves to VS2", 1, 6'b111000);
        step(1, 0, 1, 1, 5, 0, "R4 quad vint blocks fp on VS2", 1, 6'b100010);
        step(1, 2, 0, 1, 4, 1, "R4 quad fp beside perm", 1, 6'b111000);
        // R6 one grant per pipe
        step(1, 0, 0, 1, 1, 0, "R6 two VS1-only", 1, 6'b100010);

        // R5 gap of 4: allowed
        do_reset();
        step(1, 5, 0, 0, 0, 0, "R5 vfp to VS1", 1, 6'b100000);
        for (int i = 0; i < 3; i++) idle("R5 idle");
        step(1, 1, 0, 0, 0, 0, "R5 xs at gap 4 granted", 1, 6'b100000);

        // R5 gap of 5: blocked, R7 held candidate and in-order stall
        do_reset();
        step(1, 5, 0, 0, 0, 0, "R5 vfp to VS1", 1, 6'b100000);
        for (int i = 0; i < 4; i++) idle("R5 idle");
        step(1, 1, 0, 1, 2, 0, "R5 xs at gap 5 blocked, R7 younger waits", 1, 6'b000011);
        step(1, 1, 0, 1, 2, 0, "R5 xs at gap 6 granted, R7 held pair placed", 1, 6'b101100);

        // R8 reset wipes the history
        do_reset();
        step(1, 5, 0, 0, 0, 0, "R8 vfp before reset", 1, 6'b100000);
        idle("R8 idle");
        do_reset();
        idle("R8 idle");
        step(1, 1, 0, 0, 0, 0, "R8 xs not blocked after reset", 1, 6'b100000);

        // sweep all slot combinations, history tracked by the model
        do_reset();
        for (int va = 0; va < 2; va++)
            for (int vb = 0; vb < 2; vb++)
                for (int ka = 0; ka < 6; ka++)
                    for (int kb = 0; kb < 6; kb++)
                        for (int qa = 0; qa < 2; qa++)
                            for (int qb = 0; qb < 2; qb++)
                                step(1'(va), ka, 1'(qa), 1'(vb), kb, 1'(qb),
                                     "sweep R1/R2/R3/R4/R5/R6/R7", 0, 6'b000000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule